// File: doc/BRIEF.md
# Single-Word DDR SDRAM Access Controller

This block sits between a simple host request port and one DDR SDRAM device. It serves one word per request, read or write. The device has no burst length of one, so the block programs the device for full-page bursts during power-up. It then reduces every access to one two-beat pair. It issues a burst-terminate right after the pair. On writes the data mask covers the beat that is not wanted. On reads both beats are captured and only the addressed one is kept.

The host address is `{bank, row, column}` with the column in the low bits. The block opens the row, waits the activate-to-column time and issues the column command with column bit 0 cleared. It ends the burst, then precharges the bank. Column bit 0 picks the beat: 0 is the rising-edge beat and 1 is the falling-edge beat.

The request side is a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The host must hold a pending request and all its fields stable until that edge. `req_ready` falls on the next cycle and stays low until the precharge time after the closing precharge has elapsed. The read response has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take.

A periodic auto-refresh is raised internally and serviced between accesses. The data path works at logic level. Each clock carries a rising beat and a falling beat as separate buses. Delay calibration is left to the physical layer. All timing parameters are in clock cycles and must be at least 2. The row width must be at least 11 and the column width at most 10.

Top module: `ddr1w_ctrl`

## Requirements
- R1: After reset, the first four non-NOP commands, in order, are: precharge with address bit 10 high, mode-register set, auto-refresh, and auto-refresh. `req_ready` stays low until all four have been issued.
- R2: The mode-register set drives bank 0. Its address word has bits [2:0] = 3'b111 (full-page burst), bit 3 = 0 (sequential), bits [6:4] = CL, and every other bit 0.
- R3: An activate carries the bank and row fields of the accepted address. At least T_RCD cycles pass from an activate to the following read or write command.
- R4: A read or write command carries the request's column with bit 0 forced to 0, and has address bit 10 low (no auto-precharge).
- R5: In the cycle after a write command, `dq_oe` is high and both beats carry the write data. The addressed beat has mask `~req_be` and the other beat has an all-ones mask. Only the unmasked bytes of the addressed word change in the device.
- R6: A burst-terminate is issued in the cycle after every read command. For writes it is issued in the cycle after the write data cycle.
- R7: A read captures both beats CL cycles after its read command. It returns the rising beat for an even column and the falling beat for an odd column. `rsp_valid` is high for exactly one cycle, T_RCD+CL+1 cycles after the acceptance cycle.
- R8: After a precharge, no activate, refresh or mode-register set is issued for T_RP cycles.
- R9: `req_ready` is low from the cycle after acceptance until at least T_RP cycles after the closing precharge. Each request held valid is accepted exactly once, giving one activate.
- R10: An auto-refresh falls due every REFI cycles after initialization. It is issued only from idle with no row open, ahead of a waiting request. The gap between refreshes never exceeds REFI plus one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BA_W+ROW_W+COL_W | {bank, row, column} word address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables for a write |
| rsp_valid | output | 1 | One-cycle pulse: read word valid |
| rsp_data | output | DW | Read word |
| ddr_cs_n | output | 1 | Chip select |
| ddr_ras_n | output | 1 | Row strobe |
| ddr_cas_n | output | 1 | Column strobe |
| ddr_we_n | output | 1 | Write enable |
| ddr_ba | output | BA_W | Bank address |
| ddr_a | output | ROW_W | Address bus |
| dq_oe | output | 1 | Data bus driven (write data cycle) |
| dqs_oe | output | 1 | Data strobe driven (preamble and data cycle) |
| dq_wr_rise | output | DW | Write data, rising beat |
| dq_wr_fall | output | DW | Write data, falling beat |
| dm_rise | output | DW/8 | Byte mask, rising beat (1 = not stored) |
| dm_fall | output | DW/8 | Byte mask, falling beat |
| dq_rd_rise | input | DW | Read data captured on the rising beat |
| dq_rd_fall | input | DW | Read data captured on the falling beat |

## Verification
The bound checker watches the command pins on every cycle. It covers the activate-to-column and precharge-to-activate spacing, a burst-terminate right after each read and after each write data cycle, and at least one fully masked beat per write. It also covers the single-cycle response pulse, `req_ready` staying low while column, terminate or precharge commands are out, and refresh only with all rows closed. Only the bench scenarios can show the power-up order and mode word, the beat selection for even and odd columns, byte merging in the stored words, exact read latency, and the refresh spacing. The bench shows these through a memory model and a shadow copy of its contents.

// File: rtl/ddr1w_pkg.sv
package ddr1w_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_IPRE, ST_IMRS, ST_IREF0, ST_IREF1,
    ST_IDLE, ST_WAIT, ST_COL, ST_WDATA,
    ST_WEND, ST_RBST, ST_RDATA, ST_PRE
  } ctl_state_e;

  localparam logic [2:0] BL_FULL_PAGE = 3'b111;
endpackage

// File: rtl/ddr1w_wait_timer.sv
module ddr1w_wait_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/ddr1w_refresh_timer.sv
module ddr1w_refresh_timer #(
  parameter int REFI = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic due
);
  localparam int RW = $clog2(REFI + 1);
  localparam logic [RW-1:0] LAST = RW'(REFI - 1);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      if (ack) due <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt <= '0;
        due <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr1w_beat_lane.sv
module ddr1w_beat_lane #(
  parameter int DW = 16
) (
  input  logic            sel_odd,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   rd_rise,
  input  logic [DW-1:0]   rd_fall,
  output logic [DW-1:0]   wr_rise,
  output logic [DW-1:0]   wr_fall,
  output logic [DW/8-1:0] dm_rise,
  output logic [DW/8-1:0] dm_fall,
  output logic [DW-1:0]   rd_word
);
  localparam int BW = DW / 8;

  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign dm_rise[b] = sel_odd | ~be[b];
    assign dm_fall[b] = ~sel_odd | ~be[b];
  end

  assign wr_rise = wdata;
  assign wr_fall = wdata;
  assign rd_word = sel_odd ? rd_fall : rd_rise;
endmodule

// File: rtl/ddr1w_ctrl.sv
module ddr1w_ctrl
  import ddr1w_pkg::*;
#(
  parameter int DW    = 16,
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int T_RCD = 3,
  parameter int CL    = 2,
  parameter int T_RP  = 3,
  parameter int T_RFC = 10,
  parameter int T_MRD = 2,
  parameter int T_WR  = 3,
  parameter int REFI  = 1560
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [BA_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]               req_wdata,
  input  logic [DW/8-1:0]             req_be,
  output logic                        rsp_valid,
  output logic [DW-1:0]               rsp_data,
  output logic                        ddr_cs_n,
  output logic                        ddr_ras_n,
  output logic                        ddr_cas_n,
  output logic                        ddr_we_n,
  output logic [BA_W-1:0]             ddr_ba,
  output logic [ROW_W-1:0]            ddr_a,
  output logic                        dq_oe,
  output logic                        dqs_oe,
  output logic [DW-1:0]               dq_wr_rise,
  output logic [DW-1:0]               dq_wr_fall,
  output logic [DW/8-1:0]             dm_rise,
  output logic [DW/8-1:0]             dm_fall,
  input  logic [DW-1:0]               dq_rd_rise,
  input  logic [DW-1:0]               dq_rd_fall
);
  localparam int BW   = DW / 8;
  localparam int TMAX = T_RCD + CL + T_RP + T_RFC + T_MRD + T_WR;
  localparam int TW   = $clog2(TMAX + 1) + 1;
  localparam logic [TW-1:0] WT_RCD = TW'(T_RCD - 2);
  localparam logic [TW-1:0] WT_RP  = TW'(T_RP - 2);
  localparam logic [TW-1:0] WT_RFC = TW'(T_RFC - 2);
  localparam logic [TW-1:0] WT_MRD = TW'(T_MRD - 2);
  localparam logic [TW-1:0] WT_WR  = TW'(T_WR - 2);
  localparam logic [TW-1:0] WT_CL  = TW'(CL - 1);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'(((CL % 8) << 4) | int'(BL_FULL_PAGE));

  ctl_state_e state, state_nx, ret, ret_nx;
  ddr_cmd_e   cmd;
  logic [ROW_W-1:0] a_o;
  logic [BA_W-1:0]  ba_o, r_ba;
  logic [COL_W-1:0] r_col;
  logic             r_wr;
  logic [DW-1:0]    r_wdata;
  logic [BW-1:0]    r_be;
  logic             tmr_load, tmr_done, ref_due, ref_ack, accept, capture;
  logic [TW-1:0]    tmr_val;
  logic             in_init;
  logic [DW-1:0]    lane_wr_rise, lane_wr_fall, lane_rd;
  logic [BW-1:0]    lane_dm_rise, lane_dm_fall;

  wire [COL_W-1:0] q_col = req_addr[COL_W-1:0];
  wire [ROW_W-1:0] q_row = req_addr[COL_W +: ROW_W];
  wire [BA_W-1:0]  q_ba  = req_addr[COL_W+ROW_W +: BA_W];

  ddr1w_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  ddr1w_refresh_timer #(.REFI(REFI)) u_refi (
    .clk(clk), .rst_n(rst_n), .en(!in_init), .ack(ref_ack), .due(ref_due)
  );

  ddr1w_beat_lane #(.DW(DW)) u_lane (
    .sel_odd(r_col[0]), .wdata(r_wdata), .be(r_be),
    .rd_rise(dq_rd_rise), .rd_fall(dq_rd_fall),
    .wr_rise(lane_wr_rise), .wr_fall(lane_wr_fall),
    .dm_rise(lane_dm_rise), .dm_fall(lane_dm_fall), .rd_word(lane_rd)
  );

  assign in_init = (state == ST_IPRE) || (state == ST_IMRS) ||
                   (state == ST_IREF0) || (state == ST_IREF1);

  always_comb begin
    state_nx = state;
    ret_nx   = ret;
    cmd      = CMD_NOP;
    a_o      = '0;
    ba_o     = '0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_ack  = 1'b0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state)
      ST_IPRE: begin
        cmd = CMD_PRE; a_o[10] = 1'b1;
        tmr_load = 1'b1; tmr_val = WT_RP; state_nx = ST_WAIT; ret_nx = ST_IMRS;
      end
      ST_IMRS: begin
        cmd = CMD_MRS; a_o = MODE_WORD;
        tmr_load = 1'b1; tmr_val = WT_MRD; state_nx = ST_WAIT; ret_nx = ST_IREF0;
      end
      ST_IREF0: begin
        cmd = CMD_REF;
        tmr_load = 1'b1; tmr_val = WT_RFC; state_nx = ST_WAIT; ret_nx = ST_IREF1;
      end
      ST_IREF1: begin
        cmd = CMD_REF;
        tmr_load = 1'b1; tmr_val = WT_RFC; state_nx = ST_WAIT; ret_nx = ST_IDLE;
      end
      ST_IDLE: begin
        if (ref_due) begin
          cmd = CMD_REF; ref_ack = 1'b1;
          tmr_load = 1'b1; tmr_val = WT_RFC; state_nx = ST_WAIT; ret_nx = ST_IDLE;
        end else if (req_valid) begin
          accept = 1'b1;
          cmd = CMD_ACT; a_o = q_row; ba_o = q_ba;
          tmr_load = 1'b1; tmr_val = WT_RCD; state_nx = ST_WAIT; ret_nx = ST_COL;
        end
      end
      ST_WAIT: begin
        if (tmr_done) state_nx = ret;
      end
      ST_COL: begin
        ba_o = r_ba;
        a_o[COL_W-1:0] = {r_col[COL_W-1:1], 1'b0};
        if (r_wr) begin
          cmd = CMD_WR; state_nx = ST_WDATA;
        end else begin
          cmd = CMD_RD; tmr_load = 1'b1; tmr_val = WT_CL; state_nx = ST_RBST;
        end
      end
      ST_WDATA: state_nx = ST_WEND;
      ST_WEND: begin
        cmd = CMD_BST;
        tmr_load = 1'b1; tmr_val = WT_WR; state_nx = ST_WAIT; ret_nx = ST_PRE;
      end
      ST_RBST: begin
        cmd = CMD_BST; state_nx = ST_RDATA;
      end
      ST_RDATA: begin
        if (tmr_done) begin
          capture = 1'b1; state_nx = ST_PRE;
        end
      end
      ST_PRE: begin
        cmd = CMD_PRE; ba_o = r_ba;
        tmr_load = 1'b1; tmr_val = WT_RP; state_nx = ST_WAIT; ret_nx = ST_IDLE;
      end
      default: state_nx = ST_IPRE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IPRE;
      ret       <= ST_IDLE;
      r_ba      <= '0;
      r_col     <= '0;
      r_wr      <= 1'b0;
      r_wdata   <= '0;
      r_be      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state     <= state_nx;
      ret       <= ret_nx;
      rsp_valid <= capture;
      if (capture) rsp_data <= lane_rd;
      if (accept) begin
        r_ba    <= q_ba;
        r_col   <= q_col;
        r_wr    <= req_write;
        r_wdata <= req_wdata;
        r_be    <= req_be;
      end
    end
  end

  assign req_ready = (state == ST_IDLE) && !ref_due;
  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd;
  assign ddr_ba     = ba_o;
  assign ddr_a      = a_o;
  assign dq_oe      = (state == ST_WDATA);
  assign dqs_oe     = dq_oe || ((state == ST_COL) && r_wr);
  assign dq_wr_rise = dq_oe ? lane_wr_rise : '0;
  assign dq_wr_fall = dq_oe ? lane_wr_fall : '0;
  assign dm_rise    = dq_oe ? lane_dm_rise : '1;
  assign dm_fall    = dq_oe ? lane_dm_fall : '1;
endmodule

// File: rtl/ddr1w_ctrl_chk.sv
module ddr1w_ctrl_chk
  import ddr1w_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int BW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          ddr_cs_n,
  input logic          ddr_ras_n,
  input logic          ddr_cas_n,
  input logic          ddr_we_n,
  input logic          dq_oe,
  input logic [BW-1:0] dm_rise,
  input logic [BW-1:0] dm_fall
);
  logic [3:0] c;
  logic [7:0] since_act, since_pre;
  logic       row_open;
  assign c = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      since_pre <= 8'hFF;
      row_open  <= 1'b0;
    end else begin
      if (c == CMD_ACT)             since_act <= 8'd1;
      else if (since_act != 8'hFF)  since_act <= since_act + 8'd1;
      if (c == CMD_PRE)             since_pre <= 8'd1;
      else if (since_pre != 8'hFF)  since_pre <= since_pre + 8'd1;
      if (c == CMD_ACT)             row_open <= 1'b1;
      else if (c == CMD_PRE)        row_open <= 1'b0;
    end
  end

  AST_TRCD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_RD || c == CMD_WR) |-> since_act >= 8'(T_RCD)); // R3
  AST_TRP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_ACT || c == CMD_REF || c == CMD_MRS) |-> since_pre >= 8'(T_RP)); // R8
  AST_RD_THEN_BST: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_RD) |=> (c == CMD_BST)); // R6
  AST_WR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_WR) |=> dq_oe); // R5
  AST_DATA_THEN_BST: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |=> (c == CMD_BST)); // R6
  AST_ONE_BEAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ((&dm_rise) || (&dm_fall))); // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_RD || c == CMD_WR || c == CMD_BST || c == CMD_PRE) |-> !req_ready); // R9
  AST_REF_ROWS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_REF) |-> !row_open); // R10
endmodule

bind ddr1w_ctrl ddr1w_ctrl_chk #(.T_RCD(T_RCD), .T_RP(T_RP), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
  .ddr_we_n(ddr_we_n), .dq_oe(dq_oe), .dm_rise(dm_rise), .dm_fall(dm_fall)
);

// File: tb/ddr1w_ctrl_tb.sv
`timescale 1ns/1ps
module ddr1w_ctrl_tb;
  localparam int DW = 16, BA_W = 2, ROW_W = 12, COL_W = 9;
  localparam int HAW = BA_W + ROW_W + COL_W;
  localparam int T_RCD = 3, CL = 3, T_RP = 3, T_RFC = 6, T_MRD = 2, T_WR = 2;
  localparam int REFI = 300;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_BST = 4'b0110;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [HAW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid, cs_n, ras_n, cas_n, we_n, dq_oe, dqs_oe;
  logic [DW-1:0] rsp_data, wr_rise, wr_fall;
  logic [DW-1:0] rd_rise = 16'hDEAD, rd_fall = 16'hDEAD;
  logic [1:0] ba, dm_r, dm_f;
  logic [ROW_W-1:0] a;

  always #2 clk = ~clk;

  ddr1w_ctrl #(.DW(DW), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD),
    .CL(CL), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR(T_WR), .REFI(REFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ddr_cs_n(cs_n), .ddr_ras_n(ras_n),
    .ddr_cas_n(cas_n), .ddr_we_n(we_n), .ddr_ba(ba), .ddr_a(a), .dq_oe(dq_oe),
    .dqs_oe(dqs_oe), .dq_wr_rise(wr_rise), .dq_wr_fall(wr_fall), .dm_rise(dm_r),
    .dm_fall(dm_f), .dq_rd_rise(rd_rise), .dq_rd_fall(rd_fall));

  int total = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input int i);
    return DW'(i * 16'h0123 + 16'h5A5A);
  endfunction
  function automatic int idx(input int b, input int r, input int c);
    return (b << 8) | (r << 5) | c;
  endfunction

  logic [DW-1:0] mem [0:1023];   // device model
  logic [DW-1:0] shadow [0:1023]; // expected contents
  logic [ROW_W-1:0] open_row [0:3];

  // monitor and device model, sampled mid-cycle
  logic [3:0] init_cmd [0:3];
  logic [ROW_W-1:0] init_a [0:3];
  logic [BA_W-1:0] init_ba [0:3];
  int n_cmd = 0, ready_seen = 0, n_act = 0, n_ref_post = 0;
  int act_cyc = -100, pre_cyc = -100, last_ref = 0, rd_cnt = 0, rd_base = 0, wr_base = 0;
  bit wr_pend = 0;
  logic [3:0] prev_c = 4'hF, prev2_c = 4'hF;
  int cur_idx = 0; logic [1:0] cur_be = 0; bit cur_odd = 0;

  always @(negedge clk) begin
    logic [3:0] c;
    c = {cs_n, ras_n, cas_n, we_n};
    if (rst_n) begin
      if (req_ready) ready_seen = 1;
      if (c != 4'b0111 && ready_seen == 0 && n_cmd < 4) begin
        init_cmd[n_cmd] = c; init_a[n_cmd] = a; init_ba[n_cmd] = ba;
      end
      if (c != 4'b0111 && ready_seen == 0) n_cmd++;
      // read beats
      if (rd_cnt != 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin rd_rise = mem[rd_base]; rd_fall = mem[rd_base + 1]; end
      end else begin rd_rise = 16'hDEAD; rd_fall = 16'hDEAD; end
      // write data cycle
      if (wr_pend) begin
        wr_pend = 0;
        chk(dq_oe && dqs_oe, "R5 data cycle oe", {dq_oe, dqs_oe}, 2'b11);
        chk(dm_r == (cur_odd ? 2'b11 : ~cur_be), "R5 rise mask", dm_r, cur_odd ? 2'b11 : ~cur_be);
        chk(dm_f == (cur_odd ? ~cur_be : 2'b11), "R5 fall mask", dm_f, cur_odd ? ~cur_be : 2'b11);
        for (int b = 0; b < 2; b++) begin
          if (!dm_r[b]) mem[wr_base][b*8 +: 8] = wr_rise[b*8 +: 8];
          if (!dm_f[b]) mem[wr_base + 1][b*8 +: 8] = wr_fall[b*8 +: 8];
        end
      end
      if (prev_c == C_RD) chk(c == C_BST, "R6 bst after read", c, C_BST);
      if (prev2_c == C_WR) chk(c == C_BST, "R6 bst after write data", c, C_BST);
      case (c)
        C_ACT: begin open_row[ba] = a; act_cyc = cyc; n_act++; end
        C_PRE: pre_cyc = cyc;
        C_WR, C_RD: begin
          chk(cyc - act_cyc >= T_RCD, "R3 trcd", cyc - act_cyc, T_RCD);
          chk(a[0] == 0 && a[10] == 0 && a[COL_W-1:0] == COL_W'(cur_idx & 31 & ~1),
              "R4 column field", a, (cur_idx & 31 & ~1));
          if (c == C_WR) begin wr_pend = 1; wr_base = idx(ba, open_row[ba] & 7, a & 31); end
          else begin rd_cnt = CL; rd_base = idx(ba, open_row[ba] & 7, a & 31); end
        end
        default: ;
      endcase
      if (c == C_ACT || c == C_REF || c == C_MRS)
        chk(cyc - pre_cyc >= T_RP, "R8 trp", cyc - pre_cyc, T_RP);
      if (c == C_REF && ready_seen != 0) begin
        chk(cyc - last_ref <= REFI + 30, "R10 refresh gap", cyc - last_ref, REFI + 30);
        n_ref_post++;
      end
      if (c == C_REF) last_ref = cyc;
      prev2_c = prev_c; prev_c = c;
    end
  end

  int n_req = 0;
  task automatic access(input bit wr, input int b, input int r, input int col,
                        input logic [DW-1:0] d, input logic [1:0] be);
    int acc, k, h;
    logic [DW-1:0] exp;
    @(negedge clk);
    cur_idx = idx(b, r, col); cur_be = be; cur_odd = col[0];
    req_valid = 1; req_write = wr; req_wdata = d; req_be = be;
    req_addr = {BA_W'(b), ROW_W'(r), COL_W'(col)};
    while (!req_ready) @(negedge clk);
    acc = cyc; n_req++;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9 ready low after accept", req_ready, 0);
    if (wr) begin
      for (int q = 0; q < 2; q++)
        if (be[q]) shadow[cur_idx][q*8 +: 8] = d[q*8 +: 8];
    end else begin
      k = 0;
      while (!rsp_valid && k < 60) begin @(negedge clk); k++; end
      exp = shadow[cur_idx];
      chk(rsp_valid && cyc - acc == T_RCD + CL + 1, "R7 read latency", cyc - acc, T_RCD + CL + 1);
      chk(rsp_data == exp, col[0] ? "R7 odd column word" : "R7 even column word", rsp_data, exp);
      @(negedge clk);
      chk(!rsp_valid, "R7 single-cycle pulse", rsp_valid, 0);
    end
    k = 0;
    while (!req_ready && k < 60) begin @(negedge clk); k++; end
    h = cyc;
    chk(h - pre_cyc >= T_RP, "R9 ready after precharge", h - pre_cyc, T_RP);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = init_val(i); shadow[i] = init_val(i); end
    repeat (3) @(negedge clk);
    chk(!req_ready && !rsp_valid && !dq_oe && dm_r == 2'b11, "R1 reset state",
        {req_ready, rsp_valid, dq_oe, dm_r}, 5'b00011);
    rst_n = 1;
    while (!ready_seen) @(negedge clk);
    chk(n_cmd == 4, "R1 init command count", n_cmd, 4);
    chk(init_cmd[0] == C_PRE && init_a[0][10], "R1 precharge-all first", {init_cmd[0], init_a[0]}, {C_PRE, 12'h400});
    chk(init_cmd[1] == C_MRS, "R1 mode set second", init_cmd[1], C_MRS);
    chk(init_a[1] == ROW_W'((CL << 4) | 7) && init_ba[1] == 0, "R2 mode word",
        {init_ba[1], init_a[1]}, (CL << 4) | 7);
    chk(init_cmd[2] == C_REF && init_cmd[3] == C_REF, "R1 two refreshes",
        {init_cmd[2], init_cmd[3]}, {C_REF, C_REF});
    // full-word sweep
    for (int b = 0; b < 2; b++) for (int r = 0; r < 2; r++) for (int c = 0; c < 16; c++)
      access(1, b, r, c, DW'(idx(b, r, c) * 37 + 16'h1234), 2'b11);
    for (int b = 0; b < 2; b++) for (int r = 0; r < 2; r++) for (int c = 0; c < 16; c++)
      access(0, b, r, c, '0, 2'b00);
    // byte-enable sweep on an untouched row, neighbours read back
    for (int c = 0; c < 8; c++) access(1, 2, 3, c, 16'hA5C3 ^ DW'(c * 16'h1111), 2'(1 + (c % 2)));
    for (int c = 0; c < 10; c++) access(0, 2, 3, c, '0, 2'b00);
    for (int i = 0; i < 1024; i++)
      if (mem[i] != shadow[i]) chk(0, "R5 stored word", mem[i], shadow[i]);
    chk(1, "R5 device contents compared", 0, 0);
    chk(n_act == n_req, "R9 one activate per request", n_act, n_req);
    chk(n_ref_post >= 3, "R10 periodic refreshes seen", n_ref_post, 3);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=%0d expected=<100000", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule